// File: doc/BRIEF.md
# Atomic Fetch-and-Add Memory Unit

This unit sits between an execution pipeline and a single synchronous memory port. It performs the atomic add carried by a register-store instruction in its atomic-add mode, whose immediate field is zero. The pipeline supplies a base register value, a signed 16-bit displacement, an addend register value and a width select. The unit forms the effective address, reads the current memory contents there, adds the addend and writes the sum back to the same place.

The read and the write-back form one sequence that no other access can split. From the cycle after a request is taken until the write-back is granted, the unit raises a lock output that the memory arbiter uses to shut out every other requester. Two operand widths are supported. The doubleword form updates all eight bytes of a 64-bit memory word. The word form updates one 32-bit half of that word, chosen by address bit 2, and masks the other half with byte enables. The old value is not returned to any register.

A new request is stalled by holding the ready output low until the current sequence has finished. The memory port uses a request/grant handshake. Read data is valid in the cycle after a read is granted.

Top module: `afa_unit`

## Requirements
- R1: After reset the unit is idle: `req_ready_o`=1, and `busy_o`, `lock_o`, `done_o` and `mem_req_o` are all 0.
- R2: The effective address is the 64-bit base plus the 16-bit displacement sign-extended to 64 bits, truncated to ADDR_W bits. Both memory accesses present this address with its low three bits cleared.
- R3: Doubleword form (`req_wide_i`=1): the written data is the old 64-bit word plus the addend modulo 2^64, and the write uses byte enables 8'hFF.
- R4: Word form (`req_wide_i`=0, address 4-byte aligned): effective-address bit 2 selects the upper half (1) or the lower half (0). That half becomes its old value plus addend bits [31:0] modulo 2^32. The write uses byte enables 8'hF0 or 8'h0F, so the other half is left unchanged.
- R5: Each accepted request produces exactly one read and then exactly one write, both to the same address.
- R6: `lock_o` is high from the cycle after acceptance until the write is granted. `mem_req_o` is never high while `lock_o` is low.
- R7: Requests are taken only while `req_ready_o` is 1. A request held while the unit is busy is accepted only after the current `done_o`, and it then operates on the already updated memory.
- R8: `done_o` is high for one cycle, in the cycle after the write grant. In that cycle `lock_o` is low.
- R9: While `mem_req_o` is high and not granted, the address, write enable, byte enables and write data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| req_base_i | input | 64 | Base register value |
| req_off_i | input | 16 | Signed displacement |
| req_addend_i | input | 64 | Addend register value |
| req_wide_i | input | 1 | 1 = 64-bit form, 0 = 32-bit form |
| busy_o | output | 1 | Sequence in progress |
| lock_o | output | 1 | Memory lock for the arbiter |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory request |
| mem_gnt_i | input | 1 | Memory grant |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address, 8-byte aligned |
| mem_be_o | output | 8 | Write byte enables |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, valid the cycle after a read grant |

## Verification
The assertions assume that memory raises grant only against a live request and returns read data exactly one cycle after a read grant. They also assume that word-form addresses are 4-byte aligned and doubleword addresses are 8-byte aligned. The bench's memory model grants only while a request is up and returns data one cycle after the grant. Its grant delay is swept from zero to two stalled cycles. Every displacement it uses keeps the effective address aligned for the selected width, and this includes negative displacements and a base whose upper bits are discarded by truncation.

// File: rtl/afa_pkg.sv
package afa_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOCK,
    ST_READ,
    ST_RDATA,
    ST_WRITE,
    ST_DONE
  } afa_state_e;
endpackage

// File: rtl/afa_addr_gen.sv
module afa_addr_gen #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [DATA_W-1:0]   base_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic                wide_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W/8-1:0] be_o,
  output logic                lane_o
);
  localparam int BE_W   = DATA_W / 8;
  localparam int HALF_B = BE_W / 2;
  localparam int LSB_W  = $clog2(BE_W);

  logic [DATA_W-1:0] off_ext;
  logic [DATA_W-1:0] ea;

  assign off_ext = {{(DATA_W-OFF_W){off_i[OFF_W-1]}}, off_i};
  assign ea      = base_i + off_ext;
  assign addr_o  = {ea[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
  assign lane_o  = ea[LSB_W-1];

  // one enable group per half; wide form opens both
  for (genvar g = 0; g < 2; g++) begin : g_be
    assign be_o[g*HALF_B +: HALF_B] = {HALF_B{wide_i || (lane_o == g[0])}};
  end
endmodule

// File: rtl/afa_sum.sv
module afa_sum #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] addend_i,
  input  logic              wide_i,
  input  logic              lane_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] full_sum;
  logic [HALF_W-1:0] half_old;
  logic [HALF_W-1:0] half_sum;
  logic [DATA_W-1:0] merged;

  assign full_sum = old_i + addend_i;
  assign half_old = lane_i ? old_i[DATA_W-1:HALF_W] : old_i[HALF_W-1:0];
  assign half_sum = half_old + addend_i[HALF_W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign merged[g*HALF_W +: HALF_W] =
      (lane_i == g[0]) ? half_sum : old_i[g*HALF_W +: HALF_W];
  end

  assign sum_o = wide_i ? full_sum : merged;
endmodule

// File: rtl/afa_ctrl.sv
module afa_ctrl
  import afa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic mem_gnt_i,
  output logic req_ready_o,
  output logic busy_o,
  output logic lock_o,
  output logic done_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic cap_en_o,
  output logic sum_en_o
);
  afa_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_LOCK;
      ST_LOCK:  state_d = ST_READ;
      ST_READ:  if (mem_gnt_i) state_d = ST_RDATA;
      ST_RDATA: state_d = ST_WRITE;
      ST_WRITE: if (mem_gnt_i) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign cap_en_o    = req_ready_o && req_valid_i;
  assign busy_o      = (state_q == ST_LOCK) || (state_q == ST_READ) ||
                       (state_q == ST_RDATA) || (state_q == ST_WRITE);
  assign lock_o      = busy_o;
  assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign sum_en_o    = (state_q == ST_RDATA);
  assign done_o      = (state_q == ST_DONE);

  a_r6_req_under_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> lock_o);

  a_r7_accept_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (lock_o && !req_ready_o));

  a_r8_done_after_wgnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_gnt_i) |=> (done_o && !lock_o));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_gnt_i) |=> (!mem_req_o && lock_o));
endmodule

// File: rtl/afa_unit.sv
module afa_unit #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [DATA_W-1:0]   req_base_i,
  input  logic [OFF_W-1:0]    req_off_i,
  input  logic [DATA_W-1:0]   req_addend_i,
  input  logic                req_wide_i,
  output logic                busy_o,
  output logic                lock_o,
  output logic                done_o,
  output logic                mem_req_o,
  input  logic                mem_gnt_i,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [DATA_W/8-1:0] mem_be_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i
);
  localparam int BE_W = DATA_W / 8;

  logic              cap_en, sum_en, lane;
  logic [DATA_W-1:0] base_q, addend_q, sum_d, sum_q;
  logic [OFF_W-1:0]  off_q;
  logic              wide_q;
  logic [BE_W-1:0]   be;

  afa_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .mem_gnt_i   (mem_gnt_i),
    .req_ready_o (req_ready_o),
    .busy_o      (busy_o),
    .lock_o      (lock_o),
    .done_o      (done_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .cap_en_o    (cap_en),
    .sum_en_o    (sum_en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      off_q    <= '0;
      addend_q <= '0;
      wide_q   <= 1'b0;
    end else if (cap_en) begin
      base_q   <= req_base_i;
      off_q    <= req_off_i;
      addend_q <= req_addend_i;
      wide_q   <= req_wide_i;
    end
  end

  afa_addr_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base_i (base_q),
    .off_i  (off_q),
    .wide_i (wide_q),
    .addr_o (mem_addr_o),
    .be_o   (be),
    .lane_o (lane)
  );

  afa_sum #(.DATA_W(DATA_W)) u_sum (
    .old_i    (mem_rdata_i),
    .addend_i (addend_q),
    .wide_i   (wide_q),
    .lane_i   (lane),
    .sum_o    (sum_d)
  );

  // read data is live only in the cycle after the read grant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end

  assign mem_wdata_o = sum_q;
  assign mem_be_o    = mem_we_o ? be : '0;

  a_r3_wide_full_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && wide_q) |-> (mem_be_o == {BE_W{1'b1}}));

  a_r4_half_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !wide_q) |-> ($countones(mem_be_o) == BE_W/2));

  a_r9_hold_until_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) &&
      $stable(mem_we_o) && $stable(mem_be_o) && $stable(mem_wdata_o)));

  a_r2_addr_fixed_in_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && $past(lock_o)) |-> $stable(mem_addr_o));
endmodule

// File: tb/afa_unit_test.sv
module afa_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_base = '0;
  logic [15:0] req_off = '0;
  logic [63:0] req_addend = '0;
  logic        req_wide = 1'b0;
  logic        busy, lock, done;
  logic        mem_req, mem_gnt, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int gnt_delay = 0;
  int wait_ctr = 0;
  int rd_total = 0;
  int wr_total = 0;
  logic [31:0] rd_addr_last, wr_addr_last;
  logic [7:0]  wr_be_last;
  logic        wr_gnt_seen = 1'b0;
  logic [63:0] mem [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  afa_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_base_i(req_base), .req_off_i(req_off),
    .req_addend_i(req_addend), .req_wide_i(req_wide),
    .busy_o(busy), .lock_o(lock), .done_o(done),
    .mem_req_o(mem_req), .mem_gnt_i(mem_gnt), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  assign mem_gnt = mem_req && (wait_ctr >= gnt_delay);

  // memory model: one-cycle read latency, byte-enabled writes
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++)
        mem[i] <= {32'hFFFF_FFF0 + 32'(i), 32'h7FFF_FFF8 + 32'(i * 3)};
      wait_ctr  <= 0;
      mem_rdata <= '0;
    end else begin
      if (mem_req && !mem_gnt) wait_ctr <= wait_ctr + 1;
      else                     wait_ctr <= 0;
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          for (int b = 0; b < 8; b++)
            if (mem_be[b]) mem[mem_addr[6:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end else begin
          mem_rdata <= mem[mem_addr[6:3]];
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // port monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_gnt_seen) chk(done && !lock, "R8 done after write grant", {62'd0, done, lock}, 64'h2);
      wr_gnt_seen <= mem_req && mem_gnt && mem_we;
      if (mem_req) chk(lock, "R6 request under lock", {63'd0, lock}, 64'd1);
      if (busy && req_ready) chk(1'b0, "R7 ready while busy", 64'd1, 64'd0);
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          wr_total++;
          wr_addr_last = mem_addr;
          wr_be_last   = mem_be;
        end else begin
          rd_total++;
          rd_addr_last = mem_addr;
        end
      end
    end
  end

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WD_LIMIT) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
        finish_run();
      end
    end
  end

  task automatic wait_done(output logic seen);
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
  endtask

  function automatic logic [63:0] expect_word(input logic [63:0] old,
      input logic [63:0] add, input logic wide, input logic lane);
    logic [31:0] h;
    if (wide) return old + add;
    h = (lane ? old[63:32] : old[31:0]) + add[31:0];
    return lane ? {h, old[31:0]} : {old[63:32], h};
  endfunction

  task automatic do_op(input logic [63:0] base, input logic [15:0] off,
                       input logic [63:0] add, input logic wide, input int dly);
    logic [63:0] ea64, old, exp;
    logic [31:0] ea, al;
    logic [7:0]  exp_be;
    logic        seen;
    int rd0, wr0;
    ea64 = base + {{48{off[15]}}, off};
    ea   = ea64[31:0];
    al   = {ea[31:3], 3'b000};
    @(negedge clk);
    gnt_delay  = dly;
    old        = mem[ea[6:3]];
    exp        = expect_word(old, add, wide, ea[2]);
    exp_be     = wide ? 8'hFF : (ea[2] ? 8'hF0 : 8'h0F);
    rd0        = rd_total;
    wr0        = wr_total;
    req_base   = base;
    req_off    = off;
    req_addend = add;
    req_wide   = wide;
    req_valid  = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(seen);
    chk(seen, "R8 done pulse", {63'd0, seen}, 64'd1);
    if (wide) chk(mem[ea[6:3]] == exp, "R3 doubleword sum", mem[ea[6:3]], exp);
    else      chk(mem[ea[6:3]] == exp, "R4 word sum and untouched half", mem[ea[6:3]], exp);
    chk((rd_total - rd0 == 1) && (wr_total - wr0 == 1), "R5 one read one write",
        64'((rd_total - rd0) * 16 + (wr_total - wr0)), 64'h11);
    chk(rd_addr_last == al && wr_addr_last == al, "R2 effective address",
        {rd_addr_last, wr_addr_last}, {al, al});
    chk(wr_be_last == exp_be, wide ? "R3 byte enables" : "R4 byte enables",
        64'(wr_be_last), 64'(exp_be));
  endtask

  localparam logic [63:0] ADDS [4] = '{64'h1, 64'hFFFF_FFFF_FFFF_FFFF,
                                       64'h0000_0001_8000_0010, 64'h7FFF_FFFF_0000_0009};

  initial begin
    logic seen, done_before;
    logic [63:0] old, mid, fin;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !busy && !lock && !done && !mem_req, "R1 reset state",
        {59'd0, req_ready, busy, lock, done, mem_req}, 64'h10);

    // R3 sweep: doubleword, offsets -64..56 step 8
    for (int o = -64; o < 64; o += 8)
      for (int d = 0; d < 3; d++)
        do_op(64'h40, 16'(o), ADDS[(o / 8 + 8 + d) % 4], 1'b1, d);

    // R4 sweep: word, offsets -64..60 step 4, both halves
    for (int o = -64; o < 64; o += 4)
      for (int d = 0; d < 3; d++)
        do_op(64'h40, 16'(o), ADDS[(o / 4 + 16 + d) % 4], 1'b0, d);

    // R2 truncation of high base bits with negative displacement
    do_op(64'hABCD_0001_0000_0048, 16'hFFF8, 64'h5, 1'b1, 1);
    do_op(64'h1_0000_0074, 16'h8000 + 16'h0, 64'h3, 1'b0, 0);

    // R7 back-to-back: second request held while first runs
    @(negedge clk);
    gnt_delay  = 2;
    old        = mem[2];
    mid        = old + 64'd5;
    fin        = {mid[63:32], mid[31:0] + 32'd7};
    req_base   = 64'h10;
    req_off    = 16'h0;
    req_addend = 64'd5;
    req_wide   = 1'b1;
    req_valid  = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_addend  = 64'd7;
    req_wide    = 1'b0;
    done_before = 1'b0;
    for (int i = 0; i < 60 && !req_ready; i++) begin
      if (done) done_before = 1'b1;
      @(negedge clk);
    end
    chk(done_before, "R7 held request waits for done", {63'd0, done_before}, 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(seen);
    chk(mem[2] == fin, "R7 serialized result", mem[2], fin);

    repeat (4) @(negedge clk);
    chk(!lock && !busy && req_ready, "R6 lock released when idle",
        {61'd0, lock, busy, req_ready}, 64'd1);
    finish_run();
  end
endmodule